// File: doc/BRIEF.md
# Bubble-Tolerant Thermometer-to-Binary Encoder

This block turns the 63-bit thermometer word from a bank of comparators into a registered 6-bit binary code. A flash converter produces this kind of word. Bit j of the word is 1 when the input lies above reference j.

Each code position has a three-input AND detector that looks at the bit at its own level, the bit below it and the bit above it. Because the detector needs two consecutive ones under a zero, a lone 1 standing above the true edge cannot mark a transition. The detector outputs select rows of a lookup table that stores Gray words. The selected rows are merged with a bitwise OR, which models a wired-OR bus. As a result, a word with a stray extra transition gives a fixed and predictable code, not an arbitrary binary jump.

The Gray word is captured in a register. It is then converted to binary and registered a second time. A valid flag travels with the data through both stages.

Top module: `therm_binary_encoder`

## Requirements
- R1: A clean thermometer word, with ones in bits 0 to k-1 and zeros above, produces code k. The code appears two rising clock edges after the edge that samples the word.
- R2: An all-zero word produces code 0 and an all-ones word produces code 63.
- R3: A single 1 at bit k+1, with bit k equal to 0 and bit k+2 equal to 0, is ignored when bits 0 to k-1 are ones. The code is still k.
- R4: Transition line k is active when ext[k]=1, ext[k-1]=1 and ext[k+1]=0. Here ext[k] is word bit k-1, ext[0] and ext[-1] are taken as 1, and ext[64] is taken as 0. The output is the binary value of the bitwise OR of gray(k)=k XOR (k>>1) over all active lines.
- R5: code_vld equals therm_vld as sampled two rising edges earlier.
- R6: A rising edge with rst_n low clears code to 0 and code_vld to 0.
- R7: The code path runs whatever the state of therm_vld. A word sampled with therm_vld low still yields its code two edges later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| therm_vld | input | 1 | Marks the sampled thermometer word as meaningful |
| therm | input | 63 | Thermometer word; bit 0 is the lowest reference |
| code_vld | output | 1 | therm_vld delayed by two edges |
| code | output | 6 | Registered binary output code |

## Verification
The assertions assume that rst_n is held low across at least one rising edge before any checked cycle, and that therm carries known values whenever rst_n is high. The assertion that checks clean words only fires when the word sampled two edges earlier has the form 2^k-1; other words are left to the bench.

The bench starts under reset with defined inputs. It drives the word only on falling edges, then sweeps every clean level and every single-bubble placement. It also applies seeded random multi-transition words, whose expected codes come from the line rule in R4.

// File: rtl/therm_enc_pkg.sv
// Package: shared code conversions for the thermometer encoder.
// Assumes codes fit in 16 bits; callers slice to their own width.
package therm_enc_pkg;

    // Binary to reflected Gray code.
    function automatic logic [15:0] bin_to_gray(input logic [15:0] v);
        return v ^ (v >> 1);
    endfunction

    // Reflected Gray code back to binary, top bit down.
    function automatic logic [15:0] gray_to_bin(input logic [15:0] g);
        logic [15:0] b;
        b[15] = g[15];
        for (int i = 14; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/therm_edge_detect.sv
// Module: therm_edge_detect
// Marks each transition in a thermometer word with a three-input AND:
// two ones below the level and a zero at the level above.
// Assumes bit 0 is the lowest reference; virtual ones sit below bit 0
// and a virtual zero sits above the top bit. Purely combinational.
module therm_edge_detect #(
    parameter int N_CMP = 63
) (
    input  logic [N_CMP-1:0] therm,
    output logic [N_CMP:0]   lines
);
    localparam int N_LINES = N_CMP + 1;

    // ext[k+1] is the level-k view; ext[0], ext[1] are virtual ones
    logic [N_CMP+2:0] ext;

    // Pad the word with its virtual neighbours.
    always_comb ext = {1'b0, therm, 2'b11};

    // One three-input AND per output line.
    for (genvar k = 0; k < N_LINES; k++) begin : g_line
        assign lines[k] = ext[k+1] & ext[k] & ~ext[k+2];
    end

endmodule

// File: rtl/gray_or_rom.sv
// Module: gray_or_rom
// Lookup table holding gray(k) on row k; active rows merge by bitwise OR
// (a wired-OR model), so several active rows give a fixed result.
// Assumes N_LINES <= 2**CODE_W. Purely combinational.
module gray_or_rom
    import therm_enc_pkg::*;
#(
    parameter int CODE_W  = 6,
    parameter int N_LINES = 64
) (
    input  logic [N_LINES-1:0] lines,
    output logic [CODE_W-1:0]  word
);
    // Column b of the table: which rows store a 1 in Gray bit b.
    function automatic logic [N_LINES-1:0] col_mask(input int b);
        logic [N_LINES-1:0] m;
        logic [15:0]        g;
        for (int k = 0; k < N_LINES; k++) begin
            g    = bin_to_gray(16'(k));
            m[k] = g[b];
        end
        return m;
    endfunction

    // Each output bit is the OR of the rows that hold a 1 there.
    for (genvar b = 0; b < CODE_W; b++) begin : g_col
        localparam logic [N_LINES-1:0] MASK = col_mask(b);
        assign word[b] = |(lines & MASK);
    end

endmodule

// File: rtl/enc_pipe_reg.sv
// Module: enc_pipe_reg
// Plain pipeline register with synchronous active-low clear.
// Assumes the cleared value is all zeros.
module enc_pipe_reg #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture d each edge; clear while rst_n is low.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/therm_binary_encoder.sv
// Module: therm_binary_encoder (top)
// Thermometer word -> transition lines -> Gray table (OR merge) ->
// register -> Gray-to-binary -> register. Latency: two rising edges.
// Assumes a synchronous active-low reset and known inputs out of reset.
module therm_binary_encoder
    import therm_enc_pkg::*;
#(
    parameter int CODE_W = 6
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       therm_vld,
    input  logic [(1<<CODE_W)-2:0]     therm,
    output logic                       code_vld,
    output logic [CODE_W-1:0]          code
);
    localparam int N_LINES = 1 << CODE_W;
    localparam int N_CMP   = N_LINES - 1;

    logic [N_LINES-1:0] lines;
    logic [CODE_W-1:0]  gray_word;
    logic [CODE_W-1:0]  gray_q;
    logic               vld_q;
    logic [CODE_W-1:0]  bin_next;

    therm_edge_detect #(.N_CMP(N_CMP)) u_detect (
        .therm (therm),
        .lines (lines)
    );

    gray_or_rom #(.CODE_W(CODE_W), .N_LINES(N_LINES)) u_rom (
        .lines (lines),
        .word  (gray_word)
    );

    enc_pipe_reg #(.W(CODE_W + 1)) u_stage_gray (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({therm_vld, gray_word}),
        .q     ({vld_q, gray_q})
    );

    // Convert the registered Gray word back to binary.
    always_comb bin_next = CODE_W'(gray_to_bin(16'(gray_q)));

    enc_pipe_reg #(.W(CODE_W + 1)) u_stage_bin (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({vld_q, bin_next}),
        .q     ({code_vld, code})
    );

    // ---------------- assertion support ----------------
    logic              clean_in;
    logic [CODE_W-1:0] ones_in;

    // Input is a clean thermometer when therm+1 is a power of two.
    always_comb begin
        clean_in = (({1'b0, therm} + 1'b1) & {1'b0, therm}) == '0;
        ones_in  = CODE_W'($countones(therm));
    end

    // R1: a clean word of k ones yields code k two edges later
    p_clean_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2) && $past(clean_in, 2))
            |-> (code == $past(ones_in, 2)));

    // R3: a clean word drives exactly one transition line
    p_clean_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clean_in |-> $onehot(lines));

    // R4: the detector always finds at least one transition
    p_line_present_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(lines) >= 1);

    // R5: valid flag follows the input flag by two edges
    p_vld_delay_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(rst_n, 2)) |-> (code_vld == $past(therm_vld, 2)));

    // R6: leaving reset, outputs are cleared
    p_reset_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (code == '0 && !code_vld));

endmodule

// File: tb/test_therm_binary_encoder.sv
module test_therm_binary_encoder;
    localparam int CW = 6;
    localparam int NC = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          therm_vld = 1'b0;
    logic [NC-1:0] therm = '0;
    logic          code_vld;
    logic [CW-1:0] code;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;  // 250 MHz

    therm_binary_encoder #(.CODE_W(CW)) i_therm_binary_encoder (
        .clk       (clk),
        .rst_n     (rst_n),
        .therm_vld (therm_vld),
        .therm     (therm),
        .code_vld  (code_vld),
        .code      (code)
    );

    function automatic logic [NC-1:0] thermo(input int k);
        logic [NC-1:0] t = '0;
        for (int j = 0; j < k; j++) t[j] = 1'b1;
        return t;
    endfunction

    // R4 model: line rule, OR of Gray words, then back to binary
    function automatic int model(input logic [NC-1:0] t);
        logic [NC+1:0] e;
        int g = 0;
        int b = 0;
        e[0] = 1'b1;
        for (int j = 1; j <= NC; j++) e[j] = t[j-1];
        e[NC+1] = 1'b0;
        for (int k = 0; k <= NC; k++) begin
            logic low;
            low = (k == 0) ? 1'b1 : e[k-1];
            if (e[k] && low && !e[k+1]) g = g | (k ^ (k >> 1));
        end
        for (int i = CW - 1; i >= 0; i--) begin
            int up;
            up = (i == CW - 1) ? 0 : ((b >> (i + 1)) & 1);
            b = b | ((up ^ ((g >> i) & 1)) << i);
        end
        return b;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Apply one word, wait two edges, sample at the falling edge.
    task automatic run_word(input string req, input logic [NC-1:0] t,
                            input logic v, input int exp);
        @(negedge clk);
        therm = t;
        therm_vld = v;
        @(negedge clk);
        @(negedge clk);
        check(req, int'(code), exp);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            n_run++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [NC-1:0] hist_t [0:39];
        logic          hist_v [0:39];

        // R6: reset with busy inputs clears outputs
        therm = '1;
        therm_vld = 1'b1;
        repeat (3) @(negedge clk);
        check("R6 code", int'(code), 0);
        check("R6 vld", int'(code_vld), 0);
        rst_n = 1'b1;

        // R1 / R2: every clean level, valid high
        for (int k = 0; k <= NC; k++) begin
            run_word((k == 0 || k == NC) ? "R2" : "R1", thermo(k), 1'b1, k);
        end

        // R7: code path with valid low
        for (int k = 0; k <= NC; k += 9) begin
            run_word("R7", thermo(k), 1'b0, k);
        end

        // R3: isolated 1 one position above the edge
        for (int k = 0; k + 2 < NC; k++) begin
            logic [NC-1:0] t;
            t = thermo(k);
            t[k+1] = 1'b1;
            run_word("R3", t, 1'b1, k);
        end

        // R4: near-edge disturbances and fully random words
        for (int i = 0; i < 300; i++) begin
            logic [NC-1:0] t;
            int k;
            k = int'($urandom_range(0, NC));
            if (i % 2 == 0) begin
                t = thermo(k) ^ (NC'($urandom_range(0, 15)) << ((k > 2) ? k - 2 : 0));
            end else begin
                t = {$urandom, $urandom};
            end
            run_word("R4", t, 1'b1, model(t));
        end

        // R5: streaming valid pattern, compared two edges later
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (i >= 2) begin
                check("R5 vld", int'(code_vld), int'(hist_v[i-2]));
                check("R5 code", int'(code), model(hist_t[i-2]));
            end
            hist_t[i] = thermo((i * 7) % (NC + 1));
            hist_v[i] = ((i % 3) == 1);
            therm = hist_t[i];
            therm_vld = hist_v[i];
        end

        // R6: reset mid-run
        @(negedge clk);
        therm = thermo(40);
        therm_vld = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R6 code mid", int'(code), 0);
        check("R6 vld mid", int'(code_vld), 0);
        rst_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R1 after reset", int'(code), 40);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule